// File: doc/BRIEF.md
# XOR-Enabled Binary Up-Counter

This block is a binary up-counter with one clock. Two synchronous enable inputs, `en_a_i` and `en_b_i`, are combined by XOR and sampled on every rising clock edge into a one-bit enable flag. Counting is allowed when the two inputs agree (both high, or both low). It stops when they disagree. The flag takes effect one edge later: the values sampled at edge k decide whether edge k+1 advances the count. A disabled counter holds its value.

Two inputs override the enable pair. A start input (`start_i`) makes every rising edge at which it is high advance the count, whatever the enable flag holds. A master reset (`mrst_i`) clears the count at once, without waiting for a clock. It also sets the enable flag, and it takes priority over start. The count appears both in true form and as its bitwise inverse. It wraps silently from all ones to zero. Every control input is active high, so an input tied low is inactive. The exception is the enable pair: with both tied low, it permits counting.

Top module: `xor_enable_counter`

## Requirements
- R1: After reset is released, the first rising edge advances `cnt_q_o` by one, because the enable flag leaves reset set, whatever the enable inputs show at that edge.
- R2: If exactly one of `en_a_i`/`en_b_i` is 1 at rising edge k and `start_i` is 0 at edge k+1, then `cnt_q_o` is unchanged by edge k+1.
- R3: If `en_a_i` and `en_b_i` are both 1 at rising edge k, then edge k+1 advances `cnt_q_o` by exactly one.
- R4: If `en_a_i` and `en_b_i` are both 0 at rising edge k, then edge k+1 advances `cnt_q_o` by exactly one, just as when both are 1.
- R5: If `start_i` is 1 at a rising edge, that edge advances `cnt_q_o` by one, even while the enable flag is clear.
- R6: Raising `mrst_i` forces `cnt_q_o` to 0 with no clock edge, and sets the enable flag.
- R7: While `mrst_i` is 1, `cnt_q_o` stays 0 even when `start_i` is 1 at a clock edge.
- R8: `cnt_qn_o` always equals the bitwise inverse of `cnt_q_o`.
- R9: An advance from the all-ones count (255 at the default width of 8) gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counting clock, rising edge active |
| mrst_i | input | 1 | Asynchronous master reset, active high; clears the count and sets the enable flag |
| start_i | input | 1 | Start override, active high; forces an advance at each rising edge |
| en_a_i | input | 1 | Synchronous enable A, XOR-combined with B |
| en_b_i | input | 1 | Synchronous enable B, XOR-combined with A |
| cnt_q_o | output | WIDTH | Count value, true form |
| cnt_qn_o | output | WIDTH | Count value, bitwise inverse |

## Verification
Two pairs of functions can fall on the same clock edge. In the first pair, start and a clear enable flag meet, so the override must win over the hold. The bench provokes this by setting the enables unequal for one edge and then raising start on the next. In the second pair, master reset and start are high together, and the count must stay at zero. Random cycles also mix in short resets, and a reference model written from the requirements judges every edge. A directed mid-cycle reset confirms that the count clears before any clock edge.

// File: rtl/xcnt_pkg.sv
package xcnt_pkg;
   typedef enum logic {
      INC_ADDER  = 1'b0,
      INC_TOGGLE = 1'b1
   } inc_style_e;
endpackage

// File: rtl/xcnt_enable_reg.sv
module xcnt_enable_reg (
   input  logic clk_i,
   input  logic mrst_i,
   input  logic start_i,
   input  logic en_a_i,
   input  logic en_b_i,
   output logic go_o
);
   logic en_flag_q;

   always_ff @(posedge clk_i or posedge mrst_i) begin
      if (mrst_i) en_flag_q <= 1'b1;
      else        en_flag_q <= ~(en_a_i ^ en_b_i);
   end

   assign go_o = en_flag_q | start_i;
endmodule

// File: rtl/xcnt_core.sv
module xcnt_core
   import xcnt_pkg::*;
#(
   parameter int         WIDTH = 8,
   parameter inc_style_e STYLE = INC_TOGGLE
) (
   input  logic             clk_i,
   input  logic             mrst_i,
   input  logic             go_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] q_r;
   logic [WIDTH-1:0] nxt;

   generate
      if (STYLE == INC_ADDER) begin : g_adder
         localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
         always_comb nxt = go_i ? q_r + ONE : q_r;
      end else begin : g_toggle
         always_comb begin
            logic carry;
            carry = go_i;
            for (int i = 0; i < WIDTH; i++) begin
               nxt[i] = q_r[i] ^ carry;
               carry  = carry & q_r[i];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or posedge mrst_i) begin
      if (mrst_i) q_r <= '0;
      else        q_r <= nxt;
   end

   assign q_o = q_r;
endmodule

// File: rtl/xcnt_out.sv
module xcnt_out #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] q_i,
   output logic [WIDTH-1:0] q_o,
   output logic [WIDTH-1:0] qn_o
);
   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         assign q_o[b]  = q_i[b];
         assign qn_o[b] = ~q_i[b];
      end
   endgenerate
endmodule

// File: rtl/xor_enable_counter.sv
module xor_enable_counter
   import xcnt_pkg::*;
#(
   parameter int         WIDTH = 8,
   parameter inc_style_e STYLE = INC_TOGGLE
) (
   input  logic             clk_i,
   input  logic             mrst_i,
   input  logic             start_i,
   input  logic             en_a_i,
   input  logic             en_b_i,
   output logic [WIDTH-1:0] cnt_q_o,
   output logic [WIDTH-1:0] cnt_qn_o
);
   localparam int MAX_WIDTH = 64;

   generate
      if (WIDTH < 2 || WIDTH > MAX_WIDTH) begin : g_bad_width
         $error("xor_enable_counter: WIDTH out of range");
      end
   endgenerate

   logic             go;
   logic [WIDTH-1:0] cnt;

   xcnt_enable_reg u_en (
      .clk_i   (clk_i),
      .mrst_i  (mrst_i),
      .start_i (start_i),
      .en_a_i  (en_a_i),
      .en_b_i  (en_b_i),
      .go_o    (go)
   );

   xcnt_core #(.WIDTH(WIDTH), .STYLE(STYLE)) u_core (
      .clk_i  (clk_i),
      .mrst_i (mrst_i),
      .go_i   (go),
      .q_o    (cnt)
   );

   xcnt_out #(.WIDTH(WIDTH)) u_out (
      .q_i  (cnt),
      .q_o  (cnt_q_o),
      .qn_o (cnt_qn_o)
   );
endmodule

// File: rtl/xor_enable_counter_chk.sv
module xor_enable_counter_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk_i,
   input logic             mrst_i,
   input logic             start_i,
   input logic             en_a_i,
   input logic             en_b_i,
   input logic [WIDTH-1:0] cnt_q_o,
   input logic [WIDTH-1:0] cnt_qn_o
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   // R2: disagreeing enables, no start next edge -> hold
   p_hold_r2: assert property (@(posedge clk_i) disable iff (mrst_i)
      (en_a_i ^ en_b_i) ##1 !start_i |=> cnt_q_o == $past(cnt_q_o));

   // R3 / R4: agreeing enables -> advance at the following edge (wrap R9)
   p_agree_count_r3: assert property (@(posedge clk_i) disable iff (mrst_i)
      !(en_a_i ^ en_b_i) ##1 1'b1 |=> cnt_q_o == $past(cnt_q_o) + ONE);

   // R5: start forces an advance
   p_start_r5: assert property (@(posedge clk_i) disable iff (mrst_i)
      start_i |=> cnt_q_o == $past(cnt_q_o) + ONE);

   // R7: reset beats start
   p_reset_zero_r7: assert property (@(posedge clk_i)
      mrst_i |-> cnt_q_o == '0);

   // R8: complementary outputs
   p_complement_r8: assert property (@(posedge clk_i) disable iff (mrst_i)
      cnt_qn_o == ~cnt_q_o);
endmodule

bind xor_enable_counter xor_enable_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_i    (clk_i),
   .mrst_i   (mrst_i),
   .start_i  (start_i),
   .en_a_i   (en_a_i),
   .en_b_i   (en_b_i),
   .cnt_q_o  (cnt_q_o),
   .cnt_qn_o (cnt_qn_o)
);

// File: tb/xor_enable_counter_tb_top.sv
module xor_enable_counter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam logic [W-1:0] ALL1 = '1;

   logic         clk = 1'b0;
   logic         mrst = 1'b0;
   logic         start = 1'b0;
   logic         ena = 1'b0;
   logic         enb = 1'b0;
   logic [W-1:0] q, qn;

   int n_tests = 0;
   int n_fail  = 0;

   logic [W-1:0] m_cnt;
   logic         m_en;
   logic         last_a, last_b, after_rst;

   always #(CLK_PERIOD/2) clk = ~clk;

   xor_enable_counter #(.WIDTH(W)) dut_i (
      .clk_i(clk), .mrst_i(mrst), .start_i(start),
      .en_a_i(ena), .en_b_i(enb), .cnt_q_o(q), .cnt_qn_o(qn)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Called at a falling edge: drive, let one rising edge pass, check.
   task automatic step(input logic a, input logic b, input logic s, input logic r);
      string tag;
      logic  inc;
      logic [W-1:0] prev;
      ena = a; enb = b; start = s; mrst = r;
      @(posedge clk);
      prev = m_cnt;
      inc  = m_en | s;
      if (r) begin
         m_cnt = '0; m_en = 1'b1;
         tag = s ? "R7" : "R6";
      end else begin
         if (inc) m_cnt = m_cnt + 1'b1;
         m_en = ~(a ^ b);
         if (inc && prev == ALL1)      tag = "R9";
         else if (after_rst)            tag = "R1";
         else if (!inc)                 tag = "R2";
         else if (s && !(~(last_a ^ last_b))) tag = "R5";
         else if (!last_a && !last_b)   tag = "R4";
         else if (last_a && last_b)     tag = "R3";
         else                           tag = "R5";
      end
      after_rst = r;
      last_a = a; last_b = b;
      @(negedge clk);
      check(tag, q, m_cnt);
      check("R8", qn, ~q);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240917));
      m_cnt = '0; m_en = 1'b1; last_a = 0; last_b = 0; after_rst = 1'b1;
      #2 mrst = 1'b1;
      @(negedge clk);
      check("R6", q, '0);
      check("R8", qn, ~q);
      // release; first edge counts although enables disagree (R1)
      step(1, 0, 0, 0);
      step(1, 0, 0, 0);              // R2 hold
      step(1, 0, 0, 0);              // R2 hold
      step(1, 0, 1, 0);              // R5 start over clear flag
      step(1, 1, 0, 0);              // still clear flag: hold
      step(1, 1, 0, 0);              // R3
      step(0, 0, 0, 0);              // R3
      step(0, 0, 0, 0);              // R4
      step(0, 1, 0, 0);              // R4 then flag cleared
      step(0, 0, 1, 0);              // R5
      // mid-cycle asynchronous reset, checked before any edge (R6)
      mrst = 1'b1;
      #1 check("R6", q, '0);
      m_cnt = '0; m_en = 1'b1;
      step(1, 0, 1, 1);              // R7 reset with start
      step(0, 0, 1, 1);              // R7
      // count up through the wrap (R9)
      for (int i = 0; i < 260; i++) step(0, 0, 0, 0);
      for (int i = 0; i < 4; i++) step(1, 1, 1, 0);
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic a, b, s, r;
         a = 1'($urandom_range(0, 1));
         b = ($urandom_range(0, 3) == 0) ? ~a : a;
         s = ($urandom_range(0, 5) == 0);
         r = ($urandom_range(0, 60) == 0);
         step(a, b, s, r);
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule